// File: doc/BRIEF.md
# PCM highway time-slot interface

This block attaches one voice channel to a serial PCM highway. The highway runs on a bit clock, and a frame sync marks the start of each frame. On the transmit side the block takes a 16-bit two's-complement linear sample once per frame. It compresses the sample to an 8-bit A-law or mu-law code, or keeps it as a 16-bit linear word. It then shifts the result out, most significant bit first, in a programmable time slot. A zero transmit-gain code replaces the sample with the idle code of the selected coding.

On the receive side the block captures a programmable time slot from the serial data input and expands it back to 16-bit linear. It then presents the result with a one-cycle valid strobe. Linear coding carries 16 bits, so it uses the programmed slot and the slot after it. The frame length, both slot numbers, the coding and the mute are taken from input ports at each frame sync and held for the whole frame.

Top module: `pcm_slot_if`

## Requirements
- R1: After reset and before the first frame sync, dx_oe_o, dx_o and rx_valid_o stay low.
- R2: frame_sel_i selects the frame length: 0 gives 24 slots, 1 gives 32, 2 gives 64 and 3 gives 128 slots of 8 bits each. The highest slot of each length can be used.
- R3: A frame sync sampled high on a rising clock edge makes the next clock cycle bit 0 of slot 0. Slot s covers bit cycles 8s to 8s+7. dx_oe_o is high exactly during the transmit slot's bit cycles, and dx_o carries the word MSB first there. dx_o is low in every other cycle.
- R4: dr_i is sampled MSB first on the rising edge that ends each bit cycle of the receive slot. rx_valid_o pulses for one cycle, in the cycle after the last bit, with rx_sample_o holding the expanded word.
- R5: With linear_i low, law_mu_i = 0 selects A-law and law_mu_i = 1 selects mu-law encoding. Examples: A-law codes 1000 as 0xFA, -1000 as 0x7A and 32767 as 0xAA. Mu-law codes 1000 as 0xCE and -1000 as 0x4E.
- R6: With linear_i high, the 16-bit word fills the programmed slot and the next slot, MSB first, in both directions, and law_mu_i has no effect.
- R7: tx_gain_i = 0x00 replaces the transmitted word with the idle code: 0xD5 for A-law, 0xFF for mu-law, 0x0000 for linear.
- R8: A slot number at or beyond the frame length, or a linear slot in the last position, suppresses that direction for the frame: dx_oe_o stays low, or no rx_valid_o pulse occurs.
- R9: The sample, gain, slots, coding and frame length are latched at the frame sync. Changing them during the frame has no effect on that frame.
- R10: Receive expansion follows the same law. A-law 0xFA gives 1008 and 0x7A gives -1008. Mu-law 0xCE gives 988 and 0x4E gives -988.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Highway bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fsync_i | input | 1 | Frame sync, one cycle high per frame |
| frame_sel_i | input | 2 | Frame length select (24/32/64/128 slots) |
| tx_slot_i | input | 7 | Transmit slot number |
| rx_slot_i | input | 7 | Receive slot number |
| law_mu_i | input | 1 | 0 = A-law, 1 = mu-law |
| linear_i | input | 1 | 1 = 16-bit linear coding over two slots |
| tx_gain_i | input | 8 | Transmit gain code, 0x00 mutes |
| tx_sample_i | input | 16 | Linear transmit sample |
| dr_i | input | 1 | Serial receive data |
| dx_o | output | 1 | Serial transmit data |
| dx_oe_o | output | 1 | Transmit data output enable |
| rx_sample_o | output | 16 | Expanded receive sample |
| rx_valid_o | output | 1 | One-cycle strobe for rx_sample_o |

## Verification
The assertions assume that the block sees reset before its first clock, that fsync_i is a single-cycle pulse, and that the configuration presented with a pulse is meant for the frame it starts. The checker derives its suppression flags from that configuration, and the single-strobe property relies on fsync not arriving inside a receive slot. The stimulus drives every input on the falling edge, raises fsync for exactly one cycle with the new configuration beside it, and lets each frame run to its full length before the next pulse. Any disturbance of the inputs happens only after the pulse has been sampled.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;

  localparam int WORD_W = 16;
  localparam int CODE_W = 8;

  typedef struct packed {
    logic en;
    logic lin;
    logic mu;
  } lane_cfg_t;

  function automatic logic [7:0] slot_count(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8'd24;
      2'd1:    return 8'd32;
      2'd2:    return 8'd64;
      default: return 8'd128;
    endcase
  endfunction

  function automatic logic slot_usable(input logic [7:0] slot, input logic [1:0] sel,
                                       input logic lin);
    logic [7:0] n;
    n = slot_count(sel);
    return (slot < n) && !(lin && (slot == n - 8'd1));
  endfunction

  function automatic logic [7:0] mu_encode(input logic [15:0] x);
    logic       neg;
    logic [15:0] mag;
    logic [2:0] e;
    logic [3:0] m;
    neg = x[15];
    mag = neg ? 16'(-x) : x;
    if (mag > 16'd32635) mag = 16'd32635;
    mag = mag + 16'd132;
    e = '0;
    for (int i = 0; i < 7; i++) if (mag[8+i]) e = 3'(i + 1);
    m = 4'(mag >> (4'(e) + 4'd3));
    return ~{neg, e, m};
  endfunction

  function automatic logic [15:0] mu_decode(input logic [7:0] c);
    logic [7:0]  u;
    logic [15:0] t;
    u = ~c;
    t = 16'({u[3:0], 3'b000}) + 16'd132;
    t = t << u[6:4];
    return u[7] ? 16'(16'd132 - t) : 16'(t - 16'd132);
  endfunction

  function automatic logic [7:0] a_encode(input logic [15:0] x);
    logic        neg;
    logic [15:0] mag;
    logic [11:0] m;
    logic [2:0]  seg;
    logic [3:0]  aval;
    neg = x[15];
    mag = neg ? ~x : x;
    m = 12'(mag >> 3);
    seg = '0;
    for (int i = 0; i < 7; i++) if (m[5+i]) seg = 3'(i + 1);
    aval = (seg == 3'd0) ? 4'(m >> 1) : 4'(m >> seg);
    return {1'b0, seg, aval} ^ (neg ? 8'h55 : 8'hD5);
  endfunction

  function automatic logic [15:0] a_decode(input logic [7:0] c);
    logic [7:0]  a;
    logic [15:0] t;
    a = c ^ 8'h55;
    t = 16'({a[3:0], 4'b0000});
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else                t = (t + 16'h0108) << (a[6:4] - 3'd1);
    return a[7] ? t : 16'(-t);
  endfunction

  // transmit word, code left-aligned in companded mode
  function automatic logic [15:0] tx_word(input logic [15:0] smp, input logic mute,
                                          input logic lin, input logic mu);
    if (lin)       return mute ? 16'h0000 : smp;
    else if (mute) return {(mu ? 8'hFF : 8'hD5), 8'h00};
    else           return {(mu ? mu_encode(smp) : a_encode(smp)), 8'h00};
  endfunction

endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
  import pcm_slot_pkg::*;
#(
  parameter int POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fsync_i,
  input  logic [1:0]       frame_sel_i,
  output logic [POS_W-1:0] pos_o,
  output logic             synced_o
);

  logic [POS_W-1:0] pos_q, last_q;
  logic             synced_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      last_q   <= '0;
      synced_q <= 1'b0;
    end else if (fsync_i) begin
      pos_q    <= '0;
      last_q   <= POS_W'({3'b000, slot_count(frame_sel_i), 3'b000} - 14'd1);
      synced_q <= 1'b1;
    end else if (synced_q) begin
      pos_q <= (pos_q == last_q) ? '0 : pos_q + 1'b1;
    end
  end

  assign pos_o    = pos_q;
  assign synced_o = synced_q;

endmodule

// File: rtl/pcm_slot_window.sv
module pcm_slot_window #(
  parameter int SLOT_W = 7,
  localparam int POS_W = SLOT_W + 3
) (
  input  logic [POS_W-1:0]  pos_i,
  input  logic              synced_i,
  input  logic              en_i,
  input  logic              lin_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic              act_o,
  output logic [3:0]        off_o,
  output logic              last_o
);

  logic [POS_W:0] pos_x, base, lim;

  always_comb begin
    pos_x  = {1'b0, pos_i};
    base   = {1'b0, slot_i, 3'b000};
    lim    = base + (lin_i ? (POS_W+1)'(16) : (POS_W+1)'(8));
    act_o  = synced_i && en_i && (pos_x >= base) && (pos_x < lim);
    off_o  = 4'(pos_x - base);
    last_o = lin_i ? (off_o == 4'd15) : (off_o == 4'd7);
  end

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
  import pcm_slot_pkg::*;
#(
  parameter int SLOT_W = 7,
  parameter int GAIN_W = 8,
  localparam int POS_W = SLOT_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [1:0]        frame_sel_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              lin_i,
  input  logic              mu_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              synced_i,
  output logic              dx_o,
  output logic              dx_oe_o
);

  logic [WORD_W-1:0] word_q;
  logic [SLOT_W-1:0] slot_q;
  logic              en_q, lin_q, act, last_unused;
  logic [3:0]        off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      slot_q <= '0;
      en_q   <= 1'b0;
      lin_q  <= 1'b0;
    end else if (fsync_i) begin
      word_q <= tx_word(sample_i, gain_i == '0, lin_i, mu_i);
      slot_q <= slot_i;
      en_q   <= slot_usable(8'(slot_i), frame_sel_i, lin_i);
      lin_q  <= lin_i;
    end
  end

  pcm_slot_window #(.SLOT_W(SLOT_W)) i_win (
    .pos_i   (pos_i),
    .synced_i(synced_i),
    .en_i    (en_q),
    .lin_i   (lin_q),
    .slot_i  (slot_q),
    .act_o   (act),
    .off_o   (off),
    .last_o  (last_unused)
  );

  assign dx_oe_o = act;
  assign dx_o    = act & word_q[~off];

endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
  import pcm_slot_pkg::*;
#(
  parameter int SLOT_W = 7,
  localparam int POS_W = SLOT_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [1:0]        frame_sel_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              lin_i,
  input  logic              mu_i,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              synced_i,
  input  logic              dr_i,
  output logic [WORD_W-1:0] sample_o,
  output logic              valid_o
);

  lane_cfg_t         cfg_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] full, dec;
  logic              act, last;
  logic [3:0]        off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      slot_q <= '0;
    end else if (fsync_i) begin
      cfg_q  <= '{en: slot_usable(8'(slot_i), frame_sel_i, lin_i), lin: lin_i, mu: mu_i};
      slot_q <= slot_i;
    end
  end

  pcm_slot_window #(.SLOT_W(SLOT_W)) i_win (
    .pos_i   (pos_i),
    .synced_i(synced_i),
    .en_i    (cfg_q.en),
    .lin_i   (cfg_q.lin),
    .slot_i  (slot_q),
    .act_o   (act),
    .off_o   (off),
    .last_o  (last)
  );

  always_comb begin
    full = {sh_q, dr_i};
    if (cfg_q.lin)     dec = full;
    else if (cfg_q.mu) dec = mu_decode(full[CODE_W-1:0]);
    else               dec = a_decode(full[CODE_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= act && last;
      if (act) sh_q <= full[WORD_W-2:0];
      if (act && last) sample_o <= dec;
    end
  end

endmodule

// File: rtl/pcm_slot_if.sv
module pcm_slot_if
  import pcm_slot_pkg::*;
#(
  parameter int SLOT_W = 7,
  parameter int GAIN_W = 8,
  localparam int POS_W = SLOT_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic [1:0]        frame_sel_i,
  input  logic [SLOT_W-1:0] tx_slot_i,
  input  logic [SLOT_W-1:0] rx_slot_i,
  input  logic              law_mu_i,
  input  logic              linear_i,
  input  logic [GAIN_W-1:0] tx_gain_i,
  input  logic [WORD_W-1:0] tx_sample_i,
  input  logic              dr_i,
  output logic              dx_o,
  output logic              dx_oe_o,
  output logic [WORD_W-1:0] rx_sample_o,
  output logic              rx_valid_o
);

  logic [POS_W-1:0] pos;
  logic             synced;

  pcm_frame_timer #(.POS_W(POS_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .frame_sel_i(frame_sel_i),
    .pos_o      (pos),
    .synced_o   (synced)
  );

  pcm_tx_lane #(.SLOT_W(SLOT_W), .GAIN_W(GAIN_W)) i_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .frame_sel_i(frame_sel_i),
    .slot_i     (tx_slot_i),
    .lin_i      (linear_i),
    .mu_i       (law_mu_i),
    .gain_i     (tx_gain_i),
    .sample_i   (tx_sample_i),
    .pos_i      (pos),
    .synced_i   (synced),
    .dx_o       (dx_o),
    .dx_oe_o    (dx_oe_o)
  );

  pcm_rx_lane #(.SLOT_W(SLOT_W)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fsync_i    (fsync_i),
    .frame_sel_i(frame_sel_i),
    .slot_i     (rx_slot_i),
    .lin_i      (linear_i),
    .mu_i       (law_mu_i),
    .pos_i      (pos),
    .synced_i   (synced),
    .dr_i       (dr_i),
    .sample_o   (rx_sample_o),
    .valid_o    (rx_valid_o)
  );

endmodule

// File: rtl/pcm_slot_if_chk.sv
module pcm_slot_if_chk #(
  parameter int SLOT_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fsync_i,
  input logic [1:0]        frame_sel_i,
  input logic [SLOT_W-1:0] tx_slot_i,
  input logic [SLOT_W-1:0] rx_slot_i,
  input logic              linear_i,
  input logic              dx_o,
  input logic              dx_oe_o,
  input logic              rx_valid_o
);

  logic       seen_q, tx_bad_q, rx_bad_q, fs_d_q;
  logic [4:0] oe_run_q;
  logic [7:0] n;

  always_comb begin
    case (frame_sel_i)
      2'd0:    n = 8'd24;
      2'd1:    n = 8'd32;
      2'd2:    n = 8'd64;
      default: n = 8'd128;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q   <= 1'b0;
      tx_bad_q <= 1'b0;
      rx_bad_q <= 1'b0;
      fs_d_q   <= 1'b0;
      oe_run_q <= '0;
    end else begin
      fs_d_q   <= fsync_i;
      oe_run_q <= dx_oe_o ? ((oe_run_q == 5'd31) ? oe_run_q : oe_run_q + 5'd1) : 5'd0;
      if (fsync_i) begin
        seen_q   <= 1'b1;
        tx_bad_q <= (8'(tx_slot_i) >= n) || (linear_i && 8'(tx_slot_i) == n - 8'd1);
        rx_bad_q <= (8'(rx_slot_i) >= n) || (linear_i && 8'(rx_slot_i) == n - 8'd1);
      end
    end
  end

  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!dx_oe_o && !rx_valid_o)); // R1
  AST_DX_LOW_OFF_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dx_oe_o |-> !dx_o); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R4
  AST_OE_RUN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dx_oe_o |-> (oe_run_q < 5'd16)); // R6
  AST_TX_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_bad_q |-> !dx_oe_o); // R8
  AST_RX_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_bad_q && !fs_d_q) |-> !rx_valid_o); // R8

endmodule

bind pcm_slot_if pcm_slot_if_chk #(.SLOT_W(SLOT_W)) i_chk (.*);

// File: tb/test_pcm_slot_if.sv
module test_pcm_slot_if;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        fsync_i = 1'b0;
  logic [1:0]  frame_sel_i = '0;
  logic [6:0]  tx_slot_i = '0;
  logic [6:0]  rx_slot_i = '0;
  logic        law_mu_i = 1'b0;
  logic        linear_i = 1'b0;
  logic [7:0]  tx_gain_i = 8'h40;
  logic [15:0] tx_sample_i = '0;
  logic        dr_i = 1'b0;
  logic        dx_o, dx_oe_o, rx_valid_o;
  logic [15:0] rx_sample_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i; // 100 MHz

  pcm_slot_if i_pcm_slot_if (.*);

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] sel);
    case (sel)
      2'd0: return 192;
      2'd1: return 256;
      2'd2: return 512;
      default: return 1024;
    endcase
  endfunction

  // one full frame; tlen/rlen of 0 means that direction expects nothing
  task automatic run_frame(input logic [1:0] sel, input int txs, input int rxs, input bit mu,
                           input bit lin, input logic [7:0] gain, input logic [15:0] smp,
                           input logic [15:0] rxw, input int tlen, input logic [15:0] texp,
                           input int rlen, input logic [15:0] rexp, input string tag,
                           input bit scram);
    int nb, tb, rb, oe_err, vcnt, vpos, ncoll;
    logic [15:0] got, vval;
    nb = nbits_of(sel);
    tb = txs * 8;
    rb = rxs * 8;
    oe_err = 0; vcnt = 0; vpos = -1; ncoll = 0; got = '0; vval = '0;
    @(negedge clk_i);
    frame_sel_i = sel; tx_slot_i = 7'(txs); rx_slot_i = 7'(rxs);
    law_mu_i = mu; linear_i = lin; tx_gain_i = gain; tx_sample_i = smp;
    fsync_i = 1'b1;
    for (int k = 0; k <= nb; k++) begin
      @(negedge clk_i);
      if (k == 0) begin
        fsync_i = 1'b0;
        if (scram) begin
          tx_sample_i = ~tx_sample_i; tx_gain_i = ~tx_gain_i; law_mu_i = ~law_mu_i;
          linear_i = ~linear_i; tx_slot_i = tx_slot_i + 7'd1; rx_slot_i = rx_slot_i + 7'd1;
          frame_sel_i = frame_sel_i + 2'd1;
        end
      end
      if (k < nb) begin
        if (dx_oe_o !== (tlen != 0 && k >= tb && k < tb + tlen)) oe_err++;
        if (!dx_oe_o && dx_o !== 1'b0) oe_err++;
        if (dx_oe_o) begin got = {got[14:0], dx_o}; ncoll++; end
      end
      if (rx_valid_o) begin vcnt++; vpos = k; vval = rx_sample_o; end
      if (rlen != 0 && k >= rb && k < rb + rlen) dr_i = rxw[rlen - 1 - (k - rb)];
      else dr_i = k[0];
    end
    chk(oe_err == 0, "R3 enable window", 32'(oe_err), 32'd0);
    chk(ncoll == tlen, "R3 bit count", 32'(ncoll), 32'(tlen));
    if (tlen != 0)
      chk(((tlen == 16) ? got : {8'h00, got[7:0]}) == texp, {tag, " tx word"},
          32'((tlen == 16) ? got : {8'h00, got[7:0]}), 32'(texp));
    chk(vcnt == ((rlen != 0) ? 1 : 0), "R4 strobe count", 32'(vcnt), 32'((rlen != 0) ? 1 : 0));
    if (rlen != 0) begin
      chk(vpos == rb + rlen, "R4 strobe cycle", 32'(vpos), 32'(rb + rlen));
      chk(vval == rexp, {tag, " rx word"}, 32'(vval), 32'(rexp));
    end
  endtask

  task automatic t_reset;
    int bad = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    if (dx_oe_o !== 1'b0 || dx_o !== 1'b0 || rx_valid_o !== 1'b0) bad++;
    rst_ni = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      dr_i = ~dr_i;
      if (dx_oe_o !== 1'b0 || dx_o !== 1'b0 || rx_valid_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R1 quiet before sync", 32'(bad), 32'd0);
  endtask

  task automatic t_mu_law;
    run_frame(2'd1, 3, 5, 1'b1, 1'b0, 8'h40, 16'd1000, 16'h00CE, 8, 16'h00CE, 8, 16'h03DC, "R5 R10 mu", 1'b0);
    run_frame(2'd1, 7, 6, 1'b1, 1'b0, 8'h01, 16'hFC18, 16'h004E, 8, 16'h004E, 8, 16'hFC24, "R5 R10 mu neg", 1'b0);
  endtask

  task automatic t_a_law;
    run_frame(2'd0, 23, 0, 1'b0, 1'b0, 8'h80, 16'hFC18, 16'h00FA, 8, 16'h007A, 8, 16'h03F0, "R2 R5 R10 alaw", 1'b0);
    run_frame(2'd2, 63, 62, 1'b0, 1'b0, 8'hFF, 16'h7FFF, 16'h007A, 8, 16'h00AA, 8, 16'hFC10, "R2 R5 R10 alaw edge", 1'b0);
    run_frame(2'd3, 127, 1, 1'b0, 1'b0, 8'h10, 16'd1000, 16'h00FA, 8, 16'h00FA, 8, 16'h03F0, "R2 alaw 128", 1'b0);
  endtask

  task automatic t_linear;
    run_frame(2'd3, 10, 126, 1'b1, 1'b1, 8'h20, 16'h1234, 16'hBEEF, 16, 16'h1234, 16, 16'hBEEF, "R6 linear", 1'b0);
    run_frame(2'd0, 0, 22, 1'b0, 1'b1, 8'h20, 16'h8001, 16'h7FFE, 16, 16'h8001, 16, 16'h7FFE, "R6 linear edge", 1'b0);
  endtask

  task automatic t_mute;
    run_frame(2'd1, 4, 9, 1'b0, 1'b0, 8'h00, 16'd1000, 16'h00FA, 8, 16'h00D5, 8, 16'h03F0, "R7 mute alaw", 1'b0);
    run_frame(2'd1, 4, 9, 1'b1, 1'b0, 8'h00, 16'hFC18, 16'h00CE, 8, 16'h00FF, 8, 16'h03DC, "R7 mute mu", 1'b0);
    run_frame(2'd1, 30, 2, 1'b0, 1'b1, 8'h00, 16'h5A5A, 16'h1357, 16, 16'h0000, 16, 16'h1357, "R7 mute linear", 1'b0);
  endtask

  task automatic t_out_of_range;
    run_frame(2'd0, 24, 100, 1'b0, 1'b0, 8'h40, 16'd1000, 16'h00FA, 0, 16'h0000, 0, 16'h0000, "R8 beyond", 1'b0);
    run_frame(2'd1, 31, 31, 1'b1, 1'b1, 8'h40, 16'h1234, 16'hBEEF, 0, 16'h0000, 0, 16'h0000, "R8 linear last", 1'b0);
    run_frame(2'd2, 64, 127, 1'b1, 1'b0, 8'h40, 16'd1000, 16'h00CE, 0, 16'h0000, 0, 16'h0000, "R8 beyond 64", 1'b0);
  endtask

  task automatic t_latch;
    run_frame(2'd1, 2, 4, 1'b1, 1'b0, 8'h40, 16'd1000, 16'h00CE, 8, 16'h00CE, 8, 16'h03DC, "R9 latched", 1'b1);
    run_frame(2'd0, 5, 20, 1'b0, 1'b1, 8'h00, 16'h4321, 16'hA5C3, 16, 16'h0000, 16, 16'hA5C3, "R9 latched mute", 1'b1);
  endtask

  initial begin
    t_reset();
    t_mu_law();
    t_a_law();
    t_linear();
    t_mute();
    t_out_of_range();
    t_latch();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule